// File: doc/BRIEF.md
# Masked Leading/Trailing Zero Counter

This unit takes a 128-bit operand, a 128-bit mask and a direction select, and treats the operand as two independent 64-bit lanes. Within each lane, only the operand bits whose mask bit is set take part. The unit counts how many of those selected bits are zero in an unbroken run. The run starts at the most-significant end in leading mode and at the least-significant end in trailing mode. Masked-out positions are skipped entirely, so the run is measured over a sparse subsequence of the lane rather than over adjacent bit positions.

A request is presented with a one-cycle valid strobe. One clock later, the result appears with its own valid strobe. Each lane of the result carries a 7-bit count in its low bits, and the rest of the lane is zero. The result register keeps its value until the next accepted request.

Top module: `mzc_top`

## Requirements
- R1: With dir_i = 0 (leading mode), each lane's count equals the number of zero operand bits at mask-1 positions, scanned from bit 63 of the lane downward, before the first mask-1 position holding a 1. Operand 0x0123456789abcdef gives 5 under mask 0xaaaaaaaaaaaaaaaa and 9 under mask 0xcccccccccccccccc.
- R2: With dir_i = 1 (trailing mode), the same rule applies, scanning from bit 0 of the lane upward. Operand 0xfedcba9876543210 gives 4 under mask 0xaaaaaaaaaaaaaaaa and 8 under mask 0xcccccccccccccccc.
- R3: Lane 0 (bits 63:0) is counted only from operand and mask bits 63:0. Lane 1 (bits 127:64) is counted only from bits 127:64.
- R4: When no selected operand bit in a lane is 1, the lane's count equals the number of 1 bits in that lane's mask. An all-zero mask lane therefore gives 0, and an all-ones mask over a zero operand gives 64.
- R5: Each lane's count sits in bits [6:0] of that lane of result_o, and bits [63:7] of the lane are zero.
- R6: out_valid_o is in_valid_i delayed by one clock. The result of a request is on result_o in the cycle where out_valid_o is high.
- R7: While in_valid_i is low, result_o keeps its previous value, whatever the other inputs do.
- R8: While rst_ni is low, out_valid_o and result_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| dir_i | input | 1 | 0 = leading (from MSB), 1 = trailing (from LSB) |
| opnd_i | input | 128 | Operand, two 64-bit lanes |
| mask_i | input | 128 | Bit-select mask, two 64-bit lanes |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| result_o | output | 128 | Per-lane count, zero-extended |

## Verification
Several properties are checked on every cycle:
- Each lane's count never exceeds the population of its mask.
- The count equals that population exactly when no selected bit is set, and is strictly below it otherwise.
- An empty mask yields zero.
- The valid strobe trails the request by one cycle.
- The result stays stable between requests.

These checks do not show that the count stops at the right place in the scan. They also do not show which end the scan starts from, or that the lanes are independent. The bench's directed scenarios show these, comparing the results against a bit-serial model that includes the worked values in R1 and R2.

// File: rtl/mzc_pkg.sv
package mzc_pkg;
  localparam int unsigned LANE_W = 64;
  localparam int unsigned LANES  = 2;

  typedef enum logic {
    SCAN_LEAD  = 1'b0,
    SCAN_TRAIL = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/mzc_orient.sv
// Presents a lane LSB-first for the scan: reversed in leading mode, unchanged in trailing mode.
module mzc_orient #(
  parameter int unsigned W = 64
) (
  input  logic         trail_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign data_o[i] = trail_i ? data_i[i] : data_i[W-1-i];
  end
endmodule

// File: rtl/mzc_lane.sv
module mzc_lane
  import mzc_pkg::*;
#(
  parameter int unsigned W     = LANE_W,
  localparam int unsigned CW   = $clog2(W + 1)
) (
  input  logic          dir_i,
  input  logic [W-1:0]  opnd_i,
  input  logic [W-1:0]  mask_i,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  op_s, mk_s;
  logic [W-1:0]  hit, first_hit, before_hit;
  logic [CW-1:0] mask_pop;

  mzc_orient #(.W(W)) u_or_op (.trail_i(dir_i == SCAN_TRAIL), .data_i(opnd_i), .data_o(op_s));
  mzc_orient #(.W(W)) u_or_mk (.trail_i(dir_i == SCAN_TRAIL), .data_i(mask_i), .data_o(mk_s));

  // Scan order is now LSB-first: isolate the first selected one; everything below it is zero-run.
  assign hit        = op_s & mk_s;
  assign first_hit  = hit & (~hit + W'(1));
  assign before_hit = first_hit - W'(1);  // all ones when no hit

  always_comb begin
    count_o  = '0;
    mask_pop = '0;
    for (int i = 0; i < W; i++) begin
      count_o  = count_o + CW'(mk_s[i] & before_hit[i]);
      mask_pop = mask_pop + CW'(mask_i[i]);
    end
  end

  always_comb begin
    if (!$isunknown({opnd_i, mask_i, dir_i})) begin
      a_r4_bounded:   assert (count_o <= mask_pop);
      a_r4_empty:     assert ((mask_i != '0) || (count_o == '0));
      a_r4_no_hit:    assert (((opnd_i & mask_i) != '0) || (count_o == mask_pop));
      a_r1_stop_early: assert (((opnd_i & mask_i) == '0) || (count_o < mask_pop));
    end
  end
endmodule

// File: rtl/mzc_top.sv
module mzc_top
  import mzc_pkg::*;
#(
  parameter int unsigned LW    = LANE_W,
  parameter int unsigned NL    = LANES,
  localparam int unsigned CW   = $clog2(LW + 1),
  localparam int unsigned TW   = LW * NL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          dir_i,
  input  logic [TW-1:0] opnd_i,
  input  logic [TW-1:0] mask_i,
  output logic          out_valid_o,
  output logic [TW-1:0] result_o
);
  logic [TW-1:0] result_d;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [CW-1:0] cnt;
    mzc_lane #(.W(LW)) u_lane (
      .dir_i  (dir_i),
      .opnd_i (opnd_i[l*LW +: LW]),
      .mask_i (mask_i[l*LW +: LW]),
      .count_o(cnt)
    );
    assign result_d[l*LW +: LW] = {{(LW-CW){1'b0}}, cnt};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= result_d;
    end
  end

  a_r6_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
endmodule

// File: tb/mzc_top_tb_top.sv
module mzc_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         dir = 1'b0;
  logic [127:0] opnd = '0;
  logic [127:0] mask = '0;
  logic         out_valid;
  logic [127:0] result;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  mzc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .dir_i(dir),
    .opnd_i(opnd), .mask_i(mask), .out_valid_o(out_valid), .result_o(result)
  );

  function automatic logic [63:0] ref_lane(logic d, logic [63:0] op, logic [63:0] mk);
    int  c = 0;
    bit  stop = 0;
    for (int i = 0; i < 64; i++) begin
      int p = d ? i : 63 - i;
      if (!stop && mk[p]) begin
        if (op[p]) stop = 1;
        else c++;
      end
    end
    return 64'(c);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request, sample one cycle later, check valid and both lanes.
  task automatic run_req(string req, logic d, logic [127:0] op, logic [127:0] mk);
    logic [127:0] exp;
    exp = {ref_lane(d, op[127:64], mk[127:64]), ref_lane(d, op[63:0], mk[63:0])};
    @(negedge clk);
    in_valid = 1'b1; dir = d; opnd = op; mask = mk;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R6 valid"}, 128'(out_valid), 128'd1);
    chk(req, result, exp);
  endtask

  task automatic t_reset;
    chk("R8 valid in reset", 128'(out_valid), 128'd0);
    chk("R8 result in reset", result, '0);
  endtask

  task automatic t_examples;
    run_req("R1 leading example", 1'b0, {2{64'h0123456789abcdef}},
            {64'hcccccccccccccccc, 64'haaaaaaaaaaaaaaaa});
    chk("R1 exact values R5", result, {64'd9, 64'd5});
    run_req("R2 trailing example", 1'b1, {2{64'hfedcba9876543210}},
            {64'hcccccccccccccccc, 64'haaaaaaaaaaaaaaaa});
    chk("R2 exact values R5", result, {64'd8, 64'd4});
  endtask

  task automatic t_no_hit;
    run_req("R4 empty mask", 1'b0, {2{64'hffffffffffffffff}}, '0);
    chk("R4 empty mask zero", result, '0);
    run_req("R4 full mask zero operand", 1'b1, '0, '1);
    chk("R4 count 64", result, {64'd64, 64'd64});
    run_req("R4 disjoint", 1'b0, {64'h5555555555555555, 64'h00ff00ff00ff00ff},
            {64'haaaaaaaaaaaaaaaa, 64'hff00ff00ff00ff00});
  endtask

  task automatic t_lanes;
    run_req("R3 lane split lead", 1'b0, {64'h8000000000000000, 64'h0000000000000001}, '1);
    chk("R3 lane values", result, {64'd0, 64'd63});
    run_req("R3 lane split trail", 1'b1, {64'h8000000000000000, 64'h0000000000000001}, '1);
    chk("R3 lane values trail", result, {64'd63, 64'd0});
    run_req("R1 sparse lead", 1'b0, {64'h0000000100000000, 64'h0f0f0f0f0f0f0f0f},
            {64'h8000000180000000, 64'hf0f0f0f0f0f0f0ff});
    run_req("R2 sparse trail", 1'b1, {64'h1000000000000000, 64'h0000000000000100},
            {64'h1000000000000003, 64'h0000000000000ff0});
  endtask

  task automatic t_hold;
    logic [127:0] prev;
    run_req("R7 setup", 1'b0, {2{64'h0000000000000010}}, '1);
    prev = result;
    @(negedge clk);
    opnd = '1; mask = '1; dir = 1'b1;
    chk("R6 valid drops", 128'(out_valid), 128'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 result held", result, prev);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1; dir = 1'b0; opnd = '0; mask = {64'h3, 64'h7};
    @(negedge clk);
    chk("R6 b2b first", result, {64'd2, 64'd3});
    dir = 1'b1; opnd = {64'h4, 64'h4}; mask = '1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 b2b second", result, {64'd2, 64'd2});
    chk("R6 b2b valid", 128'(out_valid), 128'd1);
  endtask

  task automatic t_mid_reset;
    run_req("R8 pre", 1'b0, '0, '1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 valid cleared", 128'(out_valid), 128'd0);
    chk("R8 result cleared", result, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #5;
    t_reset;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_examples;
    t_no_hit;
    t_lanes;
    t_hold;
    t_back_to_back;
    t_mid_reset;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule